// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block produces the header that a LIN bus master places on the wire at the start of every frame. A one-clock start request, together with a 6-bit frame identifier, launches a fixed sequence on a single-wire transmit output. The sequence has three parts, always in this order:

- a long dominant break;
- a recessive delimiter;
- two UART-style bytes, a synchronization byte followed by the protected identifier byte.

Dominant is logic 0 and recessive is logic 1. The line rests recessive whenever no header is in flight.

All bit timing comes from a one-clock strobe that the surrounding logic raises once per bit period at the configured bit rate. The transmit output changes only in a cycle that follows a strobe. The block shows a busy flag while a header is in progress, and raises a one-clock done flag when the identifier stop bit has ended. The master can issue a header for any identifier, including one that its own local response logic will answer. Sending the response data, forming the checksum and reception on the slave side are handled elsewhere.

Top module: `lin_hdr_tx`

## Requirements
- R1: Out of reset and whenever `busy_o` is low, `tx_o` is 1 (recessive) and `done_o` is 0.
- R2: When `start_i` is high and `busy_o` is low, `busy_o` is high in the next cycle and `tx_o` stays 1 until the first bit strobe after that. That strobe begins the break.
- R3: The break holds `tx_o` at 0 for exactly `BREAK_BITS` bit periods. `BREAK_BITS` below 13 is rejected at elaboration.
- R4: After the break, `tx_o` is 1 for exactly `DELIM_BITS` bit periods, where `DELIM_BITS` is at least 1.
- R5: The synchronization byte is sent as 10 bit periods: a start bit of 0, then the 8 data bits of 0x55 with the LSB first, then a stop bit of 1.
- R6: The identifier byte uses the same 10-bit framing. Its data bits 0..5 are the identifier latched at the accepted start. Data bit 6 is ID0^ID1^ID2^ID4. Data bit 7 is NOT(ID1^ID3^ID4^ID5).
- R7: `tx_o` changes only in the cycle right after a cycle in which `bit_tick_i` was high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the identifier in flight nor the field timing, and it starts no header afterwards.
- R9: `done_o` is high for exactly one clock, in the cycle after the strobe that ends the identifier stop bit. `busy_o` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick_i | input | 1 | One-clock strobe, once per bit period |
| start_i | input | 1 | Request to send a header |
| id_i | input | ID_W | Frame identifier, sampled when a start is accepted |
| tx_o | output | 1 | Serial line output, 0 dominant, 1 recessive |
| busy_o | output | 1 | A header is in progress |
| done_o | output | 1 | One-clock pulse when the header is complete |

## Verification
The bench builds the block with `BREAK_BITS` = 14 and `DELIM_BITS` = 2 rather than the minimum values, and it strobes once every four clocks. This exposes any off-by-one in the field counters, because an end condition tied to a hard-coded 13 or 1 would shift every later bit. The four-clock strobe spacing leaves idle clocks between strobes, so the bench can observe that the line holds still between strobes and that the first break bit waits for a strobe after the start. Identifiers 0x00, 0x3F, 0x12 and 0x2A each drive both parity bits through both of their values.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

   localparam int LIN_ID_BITS   = 6;
   localparam int LIN_BYTE_BITS = 8;
   localparam int FRAME_BITS    = LIN_BYTE_BITS + 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ALIGN,
      PH_BREAK,
      PH_DELIM,
      PH_SYNC,
      PH_IDENT
   } hdr_phase_t;

   // Build the protected identifier: 6 id bits plus two parity bits.
   function automatic logic [LIN_BYTE_BITS-1:0] protect_id(input logic [LIN_ID_BITS-1:0] id);
      logic p_even;
      logic p_odd;
      p_even = id[0] ^ id[1] ^ id[2] ^ id[4];
      p_odd  = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p_odd, p_even, id};
   endfunction

endpackage

// File: rtl/lin_hdr_frame.sv
module lin_hdr_frame #(
   parameter int DATA_W = 8,
   localparam int FRM_W = DATA_W + 2
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [FRM_W-1:0]  frame_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("lin_hdr_frame: DATA_W must be positive");
   end

   // Slot 0 carries the start bit, then the data LSB first, then the stop bit.
   assign frame_o[0]       = 1'b0;
   assign frame_o[FRM_W-1] = 1'b1;

   for (genvar i = 0; i < DATA_W; i++) begin : g_data_slot
      assign frame_o[i+1] = data_i[i];
   end

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
   import lin_hdr_pkg::*;
#(
   parameter int BREAK_BITS = 13,
   parameter int DELIM_BITS = 1,
   parameter int FRM_W      = FRAME_BITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_tick_i,
   input  logic             start_i,
   input  logic [FRM_W-1:0] sync_frame_i,
   input  logic [FRM_W-1:0] id_frame_i,
   output logic             tx_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int MAX_A = (BREAK_BITS > DELIM_BITS) ? BREAK_BITS : DELIM_BITS;
   localparam int MAX_C = (MAX_A > FRM_W) ? MAX_A : FRM_W;
   localparam int CNT_W = $clog2(MAX_C + 1);

   localparam logic [CNT_W-1:0] BRK_LAST = CNT_W'(BREAK_BITS - 1);
   localparam logic [CNT_W-1:0] DEL_LAST = CNT_W'(DELIM_BITS - 1);
   localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRM_W - 1);

   hdr_phase_t       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + 1'b1;

   function automatic logic pick(input logic [FRM_W-1:0] frm, input logic [CNT_W-1:0] idx);
      logic r;
      r = 1'b1;
      for (int i = 0; i < FRM_W; i++) begin
         if (CNT_W'(i) == idx) r = frm[i];
      end
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         tx_o    <= 1'b1;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_ALIGN;
                  busy_o  <= 1'b1;
               end
            end
            PH_ALIGN: begin
               if (bit_tick_i) begin
                  phase_q <= PH_BREAK;
                  cnt_q   <= '0;
                  tx_o    <= 1'b0;
               end
            end
            PH_BREAK: begin
               if (bit_tick_i) begin
                  if (cnt_q == BRK_LAST) begin
                     phase_q <= PH_DELIM;
                     cnt_q   <= '0;
                     tx_o    <= 1'b1;
                  end else begin
                     cnt_q <= cnt_nxt;
                  end
               end
            end
            PH_DELIM: begin
               if (bit_tick_i) begin
                  if (cnt_q == DEL_LAST) begin
                     phase_q <= PH_SYNC;
                     cnt_q   <= '0;
                     tx_o    <= sync_frame_i[0];
                  end else begin
                     cnt_q <= cnt_nxt;
                  end
               end
            end
            PH_SYNC: begin
               if (bit_tick_i) begin
                  if (cnt_q == FRM_LAST) begin
                     phase_q <= PH_IDENT;
                     cnt_q   <= '0;
                     tx_o    <= id_frame_i[0];
                  end else begin
                     cnt_q <= cnt_nxt;
                     tx_o  <= pick(sync_frame_i, cnt_nxt);
                  end
               end
            end
            PH_IDENT: begin
               if (bit_tick_i) begin
                  if (cnt_q == FRM_LAST) begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                     tx_o    <= 1'b1;
                     busy_o  <= 1'b0;
                     done_o  <= 1'b1;
                  end else begin
                     cnt_q <= cnt_nxt;
                     tx_o  <= pick(id_frame_i, cnt_nxt);
                  end
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               tx_o    <= 1'b1;
               busy_o  <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
   import lin_hdr_pkg::*;
#(
   parameter int          BREAK_BITS   = 13,
   parameter int          DELIM_BITS   = 1,
   parameter int          ID_W         = 6,
   parameter logic [7:0]  SYNC_PATTERN = 8'h55
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bit_tick_i,
   input  logic            start_i,
   input  logic [ID_W-1:0] id_i,
   output logic            tx_o,
   output logic            busy_o,
   output logic            done_o
);

   localparam int BYTE_W = LIN_BYTE_BITS;
   localparam int FRM_W  = BYTE_W + 2;

   if (BREAK_BITS < 13) begin : g_bad_break
      $error("lin_hdr_tx: BREAK_BITS must be at least 13");
   end
   if (DELIM_BITS < 1) begin : g_bad_delim
      $error("lin_hdr_tx: DELIM_BITS must be at least 1");
   end
   if (ID_W != LIN_ID_BITS) begin : g_bad_id
      $error("lin_hdr_tx: ID_W must equal 6");
   end

   logic [ID_W-1:0]   id_q;
   logic [BYTE_W-1:0] pid;
   logic [FRM_W-1:0]  sync_frame;
   logic [FRM_W-1:0]  id_frame;

   // Identifier is captured only when a start is accepted.
   always_ff @(posedge clk) begin
      if (rst) begin
         id_q <= '0;
      end else if (start_i && !busy_o) begin
         id_q <= id_i;
      end
   end

   assign pid = protect_id(id_q);

   lin_hdr_frame #(.DATA_W(BYTE_W)) u_sync_frm (
      .data_i  (SYNC_PATTERN),
      .frame_o (sync_frame)
   );

   lin_hdr_frame #(.DATA_W(BYTE_W)) u_id_frm (
      .data_i  (pid),
      .frame_o (id_frame)
   );

   lin_hdr_seq #(
      .BREAK_BITS (BREAK_BITS),
      .DELIM_BITS (DELIM_BITS),
      .FRM_W      (FRM_W)
   ) u_seq (
      .clk          (clk),
      .rst          (rst),
      .bit_tick_i   (bit_tick_i),
      .start_i      (start_i),
      .sync_frame_i (sync_frame),
      .id_frame_i   (id_frame),
      .tx_o         (tx_o),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
   input logic clk,
   input logic rst,
   input logic bit_tick_i,
   input logic start_i,
   input logic tx_o,
   input logic busy_o,
   input logic done_o
);

   assert_idle_recessive_R1: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> tx_o);

   assert_accept_start_R2: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> busy_o);

   assert_tx_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(bit_tick_i) |-> $stable(tx_o));

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
      busy_o |=> (busy_o || done_o));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o);

endmodule

bind lin_hdr_tx lin_hdr_tx_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .bit_tick_i (bit_tick_i),
   .start_i    (start_i),
   .tx_o       (tx_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/lin_hdr_tx_test.sv
module lin_hdr_tx_test;

   localparam int BK  = 14;
   localparam int DL  = 2;
   localparam int DIV = 4;
   localparam int NB  = BK + DL + 20;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       start_i = 1'b0;
   logic [5:0] id_i = '0;
   logic       tx_o, busy_o, done_o;
   int         div_cnt = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (rst) begin
         div_cnt <= 0;
         tick    <= 1'b0;
      end else begin
         div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
         tick    <= (div_cnt == DIV - 1);
      end
   end

   lin_hdr_tx #(.BREAK_BITS(BK), .DELIM_BITS(DL)) uut (
      .clk        (clk),
      .rst        (rst),
      .bit_tick_i (tick),
      .start_i    (start_i),
      .id_i       (id_i),
      .tx_o       (tx_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_pid(input logic [5:0] id);
      return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4], id};
   endfunction

   task automatic t_reset();
      check(tx_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
            {61'd0, tx_o, busy_o, done_o}, 64'h4);
   endtask

   task automatic t_header(input logic [5:0] id, input bit inject);
      logic [63:0] exp_v = '0;
      logic [63:0] act_v = '0;
      logic [7:0]  pid = ref_pid(id);
      logic        prev = 1'b1;
      int          stab = 0;
      bit          t;
      for (int k = 0; k < BK; k++) exp_v[k] = 1'b0;
      for (int k = BK; k < BK + DL; k++) exp_v[k] = 1'b1;
      exp_v[BK+DL] = 1'b0;
      for (int k = 0; k < 8; k++) exp_v[BK+DL+1+k] = k[0] ? 1'b0 : 1'b1;
      exp_v[BK+DL+9] = 1'b1;
      exp_v[BK+DL+10] = 1'b0;
      for (int k = 0; k < 8; k++) exp_v[BK+DL+11+k] = pid[k];
      exp_v[BK+DL+19] = 1'b1;

      @(negedge clk);
      start_i = 1'b1;
      id_i    = id;
      @(negedge clk);
      start_i = 1'b0;
      id_i    = ~id;
      check(busy_o === 1'b1 && tx_o === 1'b1, "R2 accept and wait for strobe",
            {62'd0, busy_o, tx_o}, 64'h3);

      for (int k = 0; k < NB; k++) begin
         forever begin
            @(posedge clk);
            t = tick;
            #1;
            start_i = 1'b0;
            if (t) break;
            if (k > 0 && tx_o !== prev) stab++;
         end
         @(negedge clk);
         act_v[k] = tx_o;
         prev = tx_o;
         if (inject && (k == 2 || k == BK + DL + 12)) begin
            start_i = 1'b1;
            id_i    = id ^ 6'h15;
         end
      end

      check(act_v[BK-1:0] == exp_v[BK-1:0], "R3 break length", act_v, exp_v);
      check(act_v[BK+DL-1:BK] == exp_v[BK+DL-1:BK], "R4 delimiter", act_v, exp_v);
      check(act_v[BK+DL+9:BK+DL] == exp_v[BK+DL+9:BK+DL], "R5 sync byte", act_v, exp_v);
      check(act_v[BK+DL+19:BK+DL+10] == exp_v[BK+DL+19:BK+DL+10],
            inject ? "R6 R8 identifier byte" : "R6 identifier byte", act_v, exp_v);
      check(stab == 0, "R7 line steady between strobes", 64'(stab), 64'd0);

      forever begin
         @(posedge clk);
         t = tick;
         if (t) break;
      end
      @(negedge clk);
      check(done_o === 1'b1 && busy_o === 1'b0 && tx_o === 1'b1, "R9 done after stop bit",
            {61'd0, done_o, busy_o, tx_o}, 64'h5);
      @(negedge clk);
      check(done_o === 1'b0, "R9 done lasts one clock", {63'd0, done_o}, 64'd0);
   endtask

   task automatic t_quiet_after();
      int bad = 0;
      repeat (3 * DIV) begin
         @(negedge clk);
         if (busy_o !== 1'b0 || tx_o !== 1'b1) bad++;
      end
      check(bad == 0, "R8 ignored start leaves no header", 64'(bad), 64'd0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_header(6'h00, 1'b0);
      t_header(6'h3F, 1'b0);
      t_header(6'h12, 1'b1);
      t_quiet_after();
      t_header(6'h2A, 1'b1);
      t_quiet_after();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule